// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs the single-cycle state transition a 32-bit RISC core makes when it enters an exception or interrupt handler. It owns the exception-related architectural registers: supervision register, exception status copy, exception return address, effective address, power-management, vector base and load-link reservation. The core keeps these registers up to date through simple write ports. Each cycle it chooses between a synchronous exception reported by the core and the pending timer and external-device interrupt requests. It shows through `exc_pend_o` whether anything is eligible.

When the core pulses `take_i`, one clock edge does all of the following. It saves the return address, taking system calls and delay slots into account. It copies the old supervision register, enters supervisor mode with translation and interrupts off, and clears the low-power enables. It invalidates the reservation and loads the handler fetch address onto `npc_o` with a one-cycle `npc_vld_o`. A code outside the defined set is reported on `err_o` and leaves every register as it was.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, sr_o = 0x00008001, lock_addr_o = 0xFFFFFFFF, and esr_o, epcr_o, eear_o, pmr_o, evbar_o, npc_o are 0; npc_vld_o, dslot_clr_o and err_o are low.
- R2: On entry, epcr_o becomes pc_i, or pc_i + 4 when the code is 12 (system call).
- R3: On entry with dslot_i high, the saved address is reduced by 4, sr_o bit 13 (delay-slot exception) is set and dslot_clr_o pulses for one cycle. Without dslot_i, bit 13 is cleared.
- R4: eear_o is loaded with pc_i only on entry with code 7 (illegal instruction); it holds otherwise.
- R5: On entry, esr_o receives the full sr_o value from before the entry edge.
- R6: On entry, sr_o clears bit 1 (tick enable), bit 2 (interrupt enable), bit 5 (data translation enable) and bit 6 (instruction translation enable), and sets bit 0 (supervisor). Other bits are kept.
- R7: On entry, pmr_o clears bit 4 (doze enable) and bit 5 (sleep enable), and lock_addr_o becomes 0xFFFFFFFF.
- R8: On entry, npc_o = code << 8, ORed with evbar_o when cfg_evbar_en_i is high, and ORed with 0xF0000000 when pre-entry sr_o bit 14 (high vector prefix) is set. npc_vld_o is high for the one cycle after the entry edge.
- R9: A timer request (code 5) is eligible only when sr_o bit 1 is set, and an external request (code 8) only when bit 2 is set. When both are eligible the timer wins. exc_pend_o shows eligibility in the same cycle.
- R10: A synchronous exception (exc_valid_i) takes priority over any interrupt request in the same cycle and uses exc_code_i.
- R11: Valid codes are 1 to 14. Taking code 0 or 15 pulses err_o for one cycle, and no register changes on that edge.
- R12: take_i with nothing eligible has no effect on any output.
- R13: Core writes to sr, pmr, evbar and the reservation take effect on the next edge. On an edge where an exception is taken, the sr, pmr and reservation writes are dropped; the evbar write still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pc_i | input | 32 | Address of the current instruction |
| exc_valid_i | input | 1 | Synchronous exception reported by core |
| exc_code_i | input | 4 | Code of the synchronous exception |
| dslot_i | input | 1 | Current instruction sits in a delay slot |
| irq_ext_i | input | 1 | External-device interrupt request |
| irq_tick_i | input | 1 | Timer interrupt request |
| take_i | input | 1 | Take-exception strobe |
| cfg_evbar_en_i | input | 1 | Configuration advertises a vector base register |
| sr_we_i | input | 1 | Supervision register write |
| sr_wdata_i | input | 32 | Supervision register write data |
| pmr_we_i | input | 1 | Power-management register write |
| pmr_wdata_i | input | 32 | Power-management write data |
| evbar_we_i | input | 1 | Vector base write |
| evbar_wdata_i | input | 32 | Vector base write data |
| lock_we_i | input | 1 | Reservation address write |
| lock_wdata_i | input | 32 | Reservation address write data |
| exc_pend_o | output | 1 | An exception or eligible interrupt is waiting |
| sr_o | output | 32 | Supervision register |
| esr_o | output | 32 | Saved status register |
| epcr_o | output | 32 | Saved return address |
| eear_o | output | 32 | Effective-address register |
| pmr_o | output | 32 | Power-management register |
| evbar_o | output | 32 | Vector base register |
| lock_addr_o | output | 32 | Load-link reservation address |
| npc_o | output | 32 | Handler fetch address |
| npc_vld_o | output | 1 | npc_o freshly loaded |
| dslot_clr_o | output | 1 | Clear the core's delay-slot flag |
| err_o | output | 1 | Unhandled exception code taken |

## Verification
`exc_pend_o` is combinational, so the bench checks it 1 ns after the inputs change, within the same cycle. Every other output is a register that changes on the rising edge where `take_i` or a write is presented. The bench drives inputs at the falling edge and advances a behavioural model at the rising edge. It compares all registered outputs at the next falling edge, which is exactly one edge after the stimulus. One-cycle pulses are expected high at that falling edge and low again at the following one.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int unsigned CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    EXC_NONE      = 4'd0,
    EXC_RESET     = 4'd1,
    EXC_BUS       = 4'd2,
    EXC_DATA_PAGE = 4'd3,
    EXC_INSN_PAGE = 4'd4,
    EXC_TICK      = 4'd5,
    EXC_ALIGN     = 4'd6,
    EXC_ILLEGAL   = 4'd7,
    EXC_EXT_IRQ   = 4'd8,
    EXC_DTLB_MISS = 4'd9,
    EXC_ITLB_MISS = 4'd10,
    EXC_RANGE     = 4'd11,
    EXC_SYSCALL   = 4'd12,
    EXC_FPU       = 4'd13,
    EXC_TRAP      = 4'd14,
    EXC_RSVD      = 4'd15
  } exc_code_e;

  // supervision register bits
  localparam int unsigned SR_SUPV      = 0;
  localparam int unsigned SR_TICK_EN   = 1;
  localparam int unsigned SR_IRQ_EN    = 2;
  localparam int unsigned SR_DMMU_EN   = 5;
  localparam int unsigned SR_IMMU_EN   = 6;
  localparam int unsigned SR_DSLOT_EXC = 13;
  localparam int unsigned SR_VEC_HIGH  = 14;

  // power-management register bits
  localparam int unsigned PM_DOZE_EN  = 4;
  localparam int unsigned PM_SLEEP_EN = 5;

  function automatic logic code_ok(logic [CODE_W-1:0] c);
    return (c >= EXC_RESET) && (c <= EXC_TRAP);
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_ext_i,
  input  logic              irq_tick_i,
  input  logic              irq_en_i,
  input  logic              tick_en_i,
  output logic              req_o,
  output logic [CODE_W-1:0] code_o
);
  logic tick_elig, ext_elig;

  assign tick_elig = irq_tick_i & tick_en_i;
  assign ext_elig  = irq_ext_i & irq_en_i;

  always_comb begin
    req_o  = 1'b1;
    code_o = EXC_NONE;
    if (exc_valid_i)    code_o = exc_code_i;
    else if (tick_elig) code_o = EXC_TICK;
    else if (ext_elig)  code_o = EXC_EXT_IRQ;
    else                req_o  = 1'b0;
  end

  p_sync_first_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |-> (req_o && code_o == exc_code_i));
  p_tick_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exc_valid_i && irq_tick_i && tick_en_i) |-> (code_o == EXC_TICK));
  p_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exc_valid_i && !(irq_tick_i && tick_en_i) && !(irq_ext_i && irq_en_i)) |-> !req_o);
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_entry_pkg::*;
#(
  parameter int unsigned          XLEN      = 32,
  parameter int unsigned          VEC_SHIFT = 8,
  parameter logic [XLEN-1:0]      HI_PREFIX = 32'hF000_0000
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   evbar_i,
  input  logic              base_en_i,
  input  logic              high_i,
  output logic [XLEN-1:0]   vec_o
);
  localparam int unsigned PAD = XLEN - CODE_W - VEC_SHIFT;

  logic [XLEN-1:0] off;
  assign off = {{PAD{1'b0}}, code_i, {VEC_SHIFT{1'b0}}};

  always_comb begin
    vec_o = off;
    if (base_en_i) vec_o = vec_o | evbar_i;
    if (high_i)    vec_o = vec_o | HI_PREFIX;
  end
endmodule

// File: rtl/exc_retaddr.sv
module exc_retaddr #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic            syscall_i,
  input  logic            dslot_i,
  output logic [XLEN-1:0] epc_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  // syscall resumes after the call; delay slot resumes at the branch
  always_comb begin
    unique case ({syscall_i, dslot_i})
      2'b10:   epc_o = pc_i + STEP;
      2'b01:   epc_o = pc_i - STEP;
      default: epc_o = pc_i;
    endcase
  end
endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_entry_pkg::*;
#(
  parameter int unsigned     XLEN   = 32,
  parameter logic [XLEN-1:0] SR_RST = 32'h0000_8001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_ok_i,
  input  logic              fire_bad_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   epc_i,
  input  logic [XLEN-1:0]   vec_i,
  input  logic              dslot_i,
  input  logic              sr_we_i,
  input  logic [XLEN-1:0]   sr_wdata_i,
  input  logic              pmr_we_i,
  input  logic [XLEN-1:0]   pmr_wdata_i,
  input  logic              evbar_we_i,
  input  logic [XLEN-1:0]   evbar_wdata_i,
  input  logic              lock_we_i,
  input  logic [XLEN-1:0]   lock_wdata_i,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   esr_o,
  output logic [XLEN-1:0]   epcr_o,
  output logic [XLEN-1:0]   eear_o,
  output logic [XLEN-1:0]   pmr_o,
  output logic [XLEN-1:0]   evbar_o,
  output logic [XLEN-1:0]   lock_addr_o,
  output logic [XLEN-1:0]   npc_o,
  output logic              npc_vld_o,
  output logic              dslot_clr_o,
  output logic              err_o
);
  logic [XLEN-1:0] sr_q, esr_q, epcr_q, eear_q, pmr_q, evbar_q, lock_q, npc_q;
  logic            vld_q, dclr_q, err_q;
  logic [XLEN-1:0] sr_entry, pmr_entry;
  logic            wr_open;

  assign wr_open = !(fire_ok_i || fire_bad_i);

  always_comb begin
    sr_entry               = sr_q;
    sr_entry[SR_TICK_EN]   = 1'b0;
    sr_entry[SR_IRQ_EN]    = 1'b0;
    sr_entry[SR_DMMU_EN]   = 1'b0;
    sr_entry[SR_IMMU_EN]   = 1'b0;
    sr_entry[SR_SUPV]      = 1'b1;
    sr_entry[SR_DSLOT_EXC] = dslot_i;
    pmr_entry              = pmr_q;
    pmr_entry[PM_DOZE_EN]  = 1'b0;
    pmr_entry[PM_SLEEP_EN] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= SR_RST;
      pmr_q  <= '0;
      lock_q <= '1;
    end else if (fire_ok_i) begin
      sr_q   <= sr_entry;
      pmr_q  <= pmr_entry;
      lock_q <= '1;
    end else if (wr_open) begin
      if (sr_we_i)   sr_q   <= sr_wdata_i;
      if (pmr_we_i)  pmr_q  <= pmr_wdata_i;
      if (lock_we_i) lock_q <= lock_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      esr_q  <= '0;
      epcr_q <= '0;
      eear_q <= '0;
      npc_q  <= '0;
    end else if (fire_ok_i) begin
      esr_q  <= sr_q;
      epcr_q <= epc_i;
      npc_q  <= vec_i;
      if (code_i == EXC_ILLEGAL) eear_q <= pc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         evbar_q <= '0;
    else if (evbar_we_i) evbar_q <= evbar_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      dclr_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      vld_q  <= fire_ok_i;
      dclr_q <= fire_ok_i & dslot_i;
      err_q  <= fire_bad_i;
    end
  end

  assign sr_o        = sr_q;
  assign esr_o       = esr_q;
  assign epcr_o      = epcr_q;
  assign eear_o      = eear_q;
  assign pmr_o       = pmr_q;
  assign evbar_o     = evbar_q;
  assign lock_addr_o = lock_q;
  assign npc_o       = npc_q;
  assign npc_vld_o   = vld_q;
  assign dslot_clr_o = dclr_q;
  assign err_o       = err_q;

  p_esr_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_ok_i |=> (esr_q == $past(sr_q)));
  p_eear_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_ok_i && code_i != EXC_ILLEGAL) |=> $stable(eear_q));
  p_lock_inval_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (lock_q == '1 && !pmr_q[PM_DOZE_EN] && !pmr_q[PM_SLEEP_EN]));
  p_sr_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (sr_q[SR_SUPV] && !sr_q[SR_IRQ_EN] && !sr_q[SR_TICK_EN]
               && !sr_q[SR_DMMU_EN] && !sr_q[SR_IMMU_EN]));
  p_dslot_mark_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (sr_q[SR_DSLOT_EXC] == dclr_q));
  p_err_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> ($stable(sr_q) && $stable(epcr_q) && !vld_q));
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int unsigned     XLEN       = 32,
  parameter int unsigned     VEC_SHIFT  = 8,
  parameter int unsigned     INSN_BYTES = 4,
  parameter logic [XLEN-1:0] HI_PREFIX  = 32'hF000_0000,
  parameter logic [XLEN-1:0] SR_RST     = 32'h0000_8001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              dslot_i,
  input  logic              irq_ext_i,
  input  logic              irq_tick_i,
  input  logic              take_i,
  input  logic              cfg_evbar_en_i,
  input  logic              sr_we_i,
  input  logic [XLEN-1:0]   sr_wdata_i,
  input  logic              pmr_we_i,
  input  logic [XLEN-1:0]   pmr_wdata_i,
  input  logic              evbar_we_i,
  input  logic [XLEN-1:0]   evbar_wdata_i,
  input  logic              lock_we_i,
  input  logic [XLEN-1:0]   lock_wdata_i,
  output logic              exc_pend_o,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   esr_o,
  output logic [XLEN-1:0]   epcr_o,
  output logic [XLEN-1:0]   eear_o,
  output logic [XLEN-1:0]   pmr_o,
  output logic [XLEN-1:0]   evbar_o,
  output logic [XLEN-1:0]   lock_addr_o,
  output logic [XLEN-1:0]   npc_o,
  output logic              npc_vld_o,
  output logic              dslot_clr_o,
  output logic              err_o
);
  logic              req;
  logic [CODE_W-1:0] code;
  logic [XLEN-1:0]   epc, vec;
  logic              fire, fire_ok, fire_bad;

  exc_arbiter u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .exc_valid_i (exc_valid_i),
    .exc_code_i  (exc_code_i),
    .irq_ext_i   (irq_ext_i),
    .irq_tick_i  (irq_tick_i),
    .irq_en_i    (sr_o[SR_IRQ_EN]),
    .tick_en_i   (sr_o[SR_TICK_EN]),
    .req_o       (req),
    .code_o      (code)
  );

  exc_retaddr #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_ret (
    .pc_i      (pc_i),
    .syscall_i (code == EXC_SYSCALL),
    .dslot_i   (dslot_i),
    .epc_o     (epc)
  );

  exc_vector #(.XLEN(XLEN), .VEC_SHIFT(VEC_SHIFT), .HI_PREFIX(HI_PREFIX)) u_vec (
    .code_i    (code),
    .evbar_i   (evbar_o),
    .base_en_i (cfg_evbar_en_i),
    .high_i    (sr_o[SR_VEC_HIGH]),
    .vec_o     (vec)
  );

  assign fire     = take_i & req;
  assign fire_ok  = fire & code_ok(code);
  assign fire_bad = fire & ~code_ok(code);

  assign exc_pend_o = req;

  exc_state #(.XLEN(XLEN), .SR_RST(SR_RST)) u_state (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fire_ok_i     (fire_ok),
    .fire_bad_i    (fire_bad),
    .code_i        (code),
    .pc_i          (pc_i),
    .epc_i         (epc),
    .vec_i         (vec),
    .dslot_i       (dslot_i),
    .sr_we_i       (sr_we_i),
    .sr_wdata_i    (sr_wdata_i),
    .pmr_we_i      (pmr_we_i),
    .pmr_wdata_i   (pmr_wdata_i),
    .evbar_we_i    (evbar_we_i),
    .evbar_wdata_i (evbar_wdata_i),
    .lock_we_i     (lock_we_i),
    .lock_wdata_i  (lock_wdata_i),
    .sr_o          (sr_o),
    .esr_o         (esr_o),
    .epcr_o        (epcr_o),
    .eear_o        (eear_o),
    .pmr_o         (pmr_o),
    .evbar_o       (evbar_o),
    .lock_addr_o   (lock_addr_o),
    .npc_o         (npc_o),
    .npc_vld_o     (npc_vld_o),
    .dslot_clr_o   (dslot_clr_o),
    .err_o         (err_o)
  );

  p_npc_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_ok && sr_o[SR_VEC_HIGH]) |=> (npc_o[31:28] == 4'hF));
endmodule

// File: tb/exc_entry_ctrl_tb_top.sv
module exc_entry_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc = '0;
  logic        exc_valid = 1'b0;
  logic [3:0]  exc_code = '0;
  logic        dslot = 1'b0, irq_ext = 1'b0, irq_tick = 1'b0, take = 1'b0, cfg_en = 1'b0;
  logic        sr_we = 1'b0, pmr_we = 1'b0, evbar_we = 1'b0, lock_we = 1'b0;
  logic [31:0] sr_wd = '0, pmr_wd = '0, evbar_wd = '0, lock_wd = '0;

  logic        pend_o, vld_o, dclr_o, err_o;
  logic [31:0] sr_o, esr_o, epcr_o, eear_o, pmr_o, evbar_o, lock_o, npc_o;

  int n_cmp = 0, n_bad = 0;
  logic done = 1'b0;

  // reference state
  logic [31:0] m_sr, m_esr, m_epcr, m_eear, m_pmr, m_evbar, m_lock, m_npc;
  logic        m_vld, m_dclr, m_err;

  always #10 clk = ~clk;

  exc_entry_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .exc_valid_i(exc_valid), .exc_code_i(exc_code),
    .dslot_i(dslot), .irq_ext_i(irq_ext), .irq_tick_i(irq_tick), .take_i(take),
    .cfg_evbar_en_i(cfg_en), .sr_we_i(sr_we), .sr_wdata_i(sr_wd), .pmr_we_i(pmr_we),
    .pmr_wdata_i(pmr_wd), .evbar_we_i(evbar_we), .evbar_wdata_i(evbar_wd),
    .lock_we_i(lock_we), .lock_wdata_i(lock_wd), .exc_pend_o(pend_o), .sr_o(sr_o),
    .esr_o(esr_o), .epcr_o(epcr_o), .eear_o(eear_o), .pmr_o(pmr_o), .evbar_o(evbar_o),
    .lock_addr_o(lock_o), .npc_o(npc_o), .npc_vld_o(vld_o), .dslot_clr_o(dclr_o),
    .err_o(err_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sr = 32'h0000_8001; m_esr = '0; m_epcr = '0; m_eear = '0; m_pmr = '0;
    m_evbar = '0; m_lock = 32'hFFFF_FFFF; m_npc = '0;
    m_vld = 1'b0; m_dclr = 1'b0; m_err = 1'b0;
  endtask

  function automatic int sel_code();
    if (exc_valid)                 return int'(exc_code);
    if (irq_tick && m_sr[1])       return 5;
    if (irq_ext && m_sr[2])        return 8;
    return -1;
  endfunction

  task automatic compare_all();
    chk("R6",  "sr",    sr_o,   m_sr);
    chk("R5",  "esr",   esr_o,  m_esr);
    chk("R2",  "epcr",  epcr_o, m_epcr);
    chk("R4",  "eear",  eear_o, m_eear);
    chk("R7",  "pmr",   pmr_o,  m_pmr);
    chk("R13", "evbar", evbar_o, m_evbar);
    chk("R7",  "lock",  lock_o, m_lock);
    chk("R8",  "npc",   npc_o,  m_npc);
    chk("R8",  "vld",   {31'd0, vld_o},  {31'd0, m_vld});
    chk("R3",  "dclr",  {31'd0, dclr_o}, {31'd0, m_dclr});
    chk("R11", "err",   {31'd0, err_o},  {31'd0, m_err});
  endtask

  // one clock: check comb pending, predict, edge, compare
  task automatic cycle();
    int c;
    logic [31:0] n_sr, n_esr, n_epcr, n_eear, n_pmr, n_evbar, n_lock, n_npc;
    logic        n_vld, n_dclr, n_err;
    #1;
    c = sel_code();
    chk("R9", "pend", {31'd0, pend_o}, {31'd0, c >= 0});
    n_sr = m_sr; n_esr = m_esr; n_epcr = m_epcr; n_eear = m_eear; n_pmr = m_pmr;
    n_lock = m_lock; n_npc = m_npc; n_evbar = evbar_we ? evbar_wd : m_evbar;
    n_vld = 1'b0; n_dclr = 1'b0; n_err = 1'b0;
    if (take && c >= 0) begin
      if (c >= 1 && c <= 14) begin
        n_esr  = m_sr;
        n_epcr = pc + ((c == 12) ? 32'd4 : 32'd0) - (dslot ? 32'd4 : 32'd0);
        if (c == 7) n_eear = pc;
        n_sr = m_sr & ~32'h0000_0066;
        n_sr = n_sr | 32'h1;
        n_sr = dslot ? (n_sr | 32'h2000) : (n_sr & ~32'h2000);
        n_pmr  = m_pmr & ~32'h30;
        n_lock = 32'hFFFF_FFFF;
        n_npc  = 32'(c) * 256;
        if (cfg_en)   n_npc = n_npc | m_evbar;
        if (m_sr[14]) n_npc = n_npc | 32'hF000_0000;
        n_vld = 1'b1; n_dclr = dslot;
      end else begin
        n_err = 1'b1;
      end
    end else begin
      if (sr_we)   n_sr   = sr_wd;
      if (pmr_we)  n_pmr  = pmr_wd;
      if (lock_we) n_lock = lock_wd;
    end
    @(posedge clk);
    m_sr = n_sr; m_esr = n_esr; m_epcr = n_epcr; m_eear = n_eear; m_pmr = n_pmr;
    m_evbar = n_evbar; m_lock = n_lock; m_npc = n_npc;
    m_vld = n_vld; m_dclr = n_dclr; m_err = n_err;
    @(negedge clk);
    compare_all();
  endtask

  task automatic quiet();
    exc_valid = 0; exc_code = 0; dslot = 0; irq_ext = 0; irq_tick = 0; take = 0;
    sr_we = 0; pmr_we = 0; evbar_we = 0; lock_we = 0;
  endtask

  task automatic wr_sr(input logic [31:0] v);
    quiet(); sr_we = 1; sr_wd = v; cycle(); quiet();
  endtask

  task automatic sync_exc(input logic [3:0] c, input logic [31:0] p, input logic ds);
    quiet(); exc_valid = 1; exc_code = c; pc = p; dslot = ds; take = 1; cycle(); quiet();
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk("R1", "sr reset", sr_o, 32'h0000_8001);
    chk("R1", "lock reset", lock_o, 32'hFFFF_FFFF);
    chk("R1", "npc reset", npc_o, 32'h0);
    chk("R1", "pulses reset", {29'd0, vld_o, dclr_o, err_o}, 32'h0);

    // R13 core writes
    quiet(); sr_we = 1; sr_wd = 32'h0000_8067; pmr_we = 1; pmr_wd = 32'h3F;
    evbar_we = 1; evbar_wd = 32'h0001_0000; lock_we = 1; lock_wd = 32'h1234_5678;
    cycle(); quiet();
    chk("R13", "sr written", sr_o, 32'h0000_8067);
    chk("R13", "lock written", lock_o, 32'h1234_5678);

    // R2 plain fault
    sync_exc(4'd2, 32'h0000_4000, 1'b0);
    chk("R2", "epcr bus", epcr_o, 32'h0000_4000);
    chk("R5", "esr copy", esr_o, 32'h0000_8067);
    chk("R6", "sr entry", sr_o, 32'h0000_8001);
    chk("R7", "pmr entry", pmr_o, 32'h0F);
    chk("R8", "npc bus", npc_o, 32'h200);
    cycle();
    chk("R8", "vld one cycle", {31'd0, vld_o}, 32'd0);

    // R2 system call
    sync_exc(4'd12, 32'h0000_5000, 1'b0);
    chk("R2", "epcr syscall", epcr_o, 32'h0000_5004);
    // R3 system call in delay slot
    sync_exc(4'd12, 32'h0000_6000, 1'b1);
    chk("R3", "epcr syscall dslot", epcr_o, 32'h0000_6000);
    // R3 alignment in delay slot
    sync_exc(4'd6, 32'h0000_7008, 1'b1);
    chk("R3", "epcr dslot", epcr_o, 32'h0000_7004);
    chk("R3", "dsx set", {31'd0, sr_o[13]}, 32'd1);
    chk("R3", "dclr pulse", {31'd0, dclr_o}, 32'd1);
    sync_exc(4'd6, 32'h0000_8000, 1'b0);
    chk("R3", "dsx cleared", {31'd0, sr_o[13]}, 32'd0);

    // R4 illegal loads eear, others keep it
    sync_exc(4'd7, 32'h0000_9abc, 1'b0);
    chk("R4", "eear illegal", eear_o, 32'h0000_9abc);
    sync_exc(4'd3, 32'h0000_1110, 1'b0);
    chk("R4", "eear held", eear_o, 32'h0000_9abc);

    // R8 base and high prefix
    wr_sr(32'h0000_4001);
    quiet(); cfg_en = 1; exc_valid = 1; exc_code = 4'd9; pc = 32'h100; take = 1; cycle(); quiet();
    chk("R8", "npc base+high", npc_o, 32'hF001_0900);
    cfg_en = 0;

    // R9 gating and tick priority
    wr_sr(32'h0000_8007);
    quiet(); irq_tick = 1; irq_ext = 1; pc = 32'h2000; take = 1; cycle(); quiet();
    chk("R9", "tick wins", npc_o, 32'h500);
    wr_sr(32'h0000_8005);
    quiet(); irq_tick = 1; irq_ext = 1; take = 1; cycle(); quiet();
    chk("R9", "ext when tick off", npc_o, 32'h800);
    // R12 nothing eligible
    wr_sr(32'h0000_8001);
    quiet(); irq_tick = 1; irq_ext = 1; take = 1; pc = 32'h3000; cycle(); quiet();
    chk("R12", "no entry", {31'd0, vld_o}, 32'd0);
    chk("R12", "epcr kept", epcr_o, m_epcr);

    // R10 sync over irq
    wr_sr(32'h0000_8007);
    quiet(); irq_tick = 1; exc_valid = 1; exc_code = 4'd11; pc = 32'h3100; take = 1; cycle(); quiet();
    chk("R10", "sync wins", npc_o, 32'hB00);

    // R11 unhandled
    sync_exc(4'd0, 32'h4444, 1'b0);
    chk("R11", "err code 0", {31'd0, err_o}, 32'd1);
    quiet(); exc_valid = 1; exc_code = 4'd15; take = 1; sr_we = 1; sr_wd = 32'hFFFF; cycle(); quiet();
    chk("R11", "err code 15", {31'd0, err_o}, 32'd1);
    chk("R11", "sr untouched", sr_o, m_sr);

    // R13 write dropped on entry edge
    quiet(); exc_valid = 1; exc_code = 4'd14; take = 1; sr_we = 1; sr_wd = 32'h0000_00FF;
    lock_we = 1; lock_wd = 32'h0; evbar_we = 1; evbar_wd = 32'h0002_0000; cycle(); quiet();
    chk("R13", "sr write dropped", {31'd0, sr_o[2]}, 32'd0);
    chk("R13", "evbar still written", evbar_o, 32'h0002_0000);

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      quiet();
      pc        = {$urandom} & 32'hFFFF_FFFC;
      exc_valid = ($urandom % 4) == 0;
      exc_code  = 4'($urandom);
      dslot     = $urandom % 2;
      irq_ext   = $urandom % 2;
      irq_tick  = $urandom % 2;
      take      = $urandom % 2;
      cfg_en    = $urandom % 2;
      sr_we     = ($urandom % 3) == 0; sr_wd = $urandom;
      pmr_we    = ($urandom % 5) == 0; pmr_wd = $urandom;
      evbar_we  = ($urandom % 7) == 0; evbar_wd = $urandom & 32'h0FFF_0000;
      lock_we   = ($urandom % 5) == 0; lock_wd = $urandom;
      cycle();
    end
    quiet();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule